// File: doc/BRIEF.md
# Reloadable Counting Register

This block is an 8-bit datapath that can either capture a word from outside or step its own stored value up by one. A bank of 2-to-1 selectors picks the source word: the external input or the stored value. That word goes through an incrementer, which adds one or leaves it unchanged. The incrementer result is the block's output, and it is also the data input of the storage register.

The register updates only on a rising clock edge. Its load control takes precedence over its clear control. If neither control is asserted, the register keeps its value. With load asserted, the stored value selected and increment asserted, the block counts up by one on each edge. With load asserted and the external word selected, it reloads.

The block has no reset pin. The stored value is unknown until the first clear or load. All controls are active high and plain level signals.

Top module: `incload_datapath`

## Requirements
- R1: With `clr`=1 and `ld`=0 at a rising edge, the stored value becomes 0x00.
- R2: With `ld`=1 at a rising edge, the stored value becomes the value `z_out` had just before that edge.
- R3: With `ld`=1 and `clr`=1 at the same edge, the load wins and the stored value becomes `z_out`, not zero.
- R4: With `ld`=0 and `clr`=0 at an edge, the stored value is unchanged, whatever `in_data`, `sel` and `inc` are.
- R5: With `inc`=0, `z_out` equals the selected word unchanged.
- R6: With `inc`=1, `z_out` equals the selected word plus one, modulo 256, so 0xFF gives 0x00. No carry is produced.
- R7: `sel`=0 selects `in_data`, and `sel`=1 selects the stored value.
- R8: Holding `ld`=1, `sel`=1 and `inc`=1 makes the stored value rise by exactly one on every edge.
- R9: `z_out` is combinational. It follows changes on `in_data`, `sel` and `inc` within the same clock period, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its rising edge |
| in_data | input | 8 | External word, selected when `sel`=0 |
| sel | input | 1 | Source select: 0 picks external word, 1 picks stored value |
| inc | input | 1 | Adds one to the selected word when 1 |
| clr | input | 1 | Synchronous clear, lower priority than `ld` |
| ld | input | 1 | Synchronous load of `z_out` into the register |
| z_out | output | 8 | Incrementer result, also the register's data input |

## Verification
The bench asserts load and clear on the same edge. A design with the usual priority would store zero there instead of the offered word. It counts through 0xFF, and it also feeds 0xFF in from outside with increment on. A design that keeps a ninth bit, or that mishandles the carry chain, would show a wrong wrap value. It also changes the external word in the middle of a clock period, which catches an output that is registered or has an extra delay. Long stretches with both controls low and the other inputs toggling show up any register that captures when it should hold.

// File: rtl/incload_pkg.sv
package incload_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/incload_mux.sv
module incload_mux #(
  parameter int unsigned W = incload_pkg::DATA_W
) (
  input  logic [W-1:0] ext_word,
  input  logic [W-1:0] fb_word,
  input  logic         pick_fb,
  output logic [W-1:0] chosen
);
  for (genvar b = 0; b < W; b++) begin : g_slice
    assign chosen[b] = pick_fb ? fb_word[b] : ext_word[b];
  end
endmodule

// File: rtl/incload_incr.sv
module incload_incr #(
  parameter int unsigned W = incload_pkg::DATA_W
) (
  input  logic [W-1:0] a,
  input  logic         bump,
  output logic [W-1:0] f
);
  logic [W-1:0] carry;
  assign carry[0] = bump;
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign f[b] = a[b] ^ carry[b];
    if (b < W - 1) begin : g_chain
      assign carry[b+1] = a[b] & carry[b];
    end
  end
endmodule

// File: rtl/incload_reg.sv
module incload_reg #(
  parameter int unsigned W = incload_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (ld)       q <= d;
    else if (clr) q <= '0;
  end

  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed_q)
    (clr && !ld) |=> (q == '0));
  p_load_r2: assert property (@(posedge clk) disable iff (!armed_q)
    ld |=> (q == $past(d)));
  p_ld_over_clr_r3: assert property (@(posedge clk) disable iff (!armed_q)
    (ld && clr) |=> (q == $past(d)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!armed_q)
    (!ld && !clr) |=> $stable(q));
endmodule

// File: rtl/incload_datapath.sv
module incload_datapath #(
  parameter int unsigned W = incload_pkg::DATA_W
) (
  input  logic         clk,
  input  logic [W-1:0] in_data,
  input  logic         sel,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  output logic [W-1:0] z_out
);
  logic [W-1:0] stored;
  logic [W-1:0] src_word;

  incload_mux #(.W(W)) u_mux (
    .ext_word(in_data), .fb_word(stored), .pick_fb(sel), .chosen(src_word)
  );

  incload_incr #(.W(W)) u_incr (
    .a(src_word), .bump(inc), .f(z_out)
  );

  incload_reg #(.W(W)) u_reg (
    .clk(clk), .clr(clr), .ld(ld), .d(z_out), .q(stored)
  );

  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  p_pass_r5: assert property (@(posedge clk) disable iff (!armed_q)
    !inc |-> (z_out == src_word));
  p_bump_r6: assert property (@(posedge clk) disable iff (!armed_q)
    inc |-> (z_out == W'(src_word + 1'b1)));
  p_src_r7: assert property (@(posedge clk) disable iff (!armed_q)
    !sel |-> (src_word == in_data));
  p_count_r8: assert property (@(posedge clk) disable iff (!armed_q)
    (ld && sel && inc) |=> (stored == W'($past(stored) + 1'b1)));
endmodule

// File: tb/test_incload_datapath.sv
module test_incload_datapath;
  logic       clk = 1'b0;
  logic [7:0] in_data = '0;
  logic       sel = 1'b0, inc = 1'b0, clr = 1'b0, ld = 1'b0;
  logic [7:0] z_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mq = 0;
  bit mknown = 1'b0;

  always #10 clk = ~clk;

  incload_datapath i_incload_datapath (
    .clk(clk), .in_data(in_data), .sel(sel), .inc(inc),
    .clr(clr), .ld(ld), .z_out(z_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  function automatic int expect_z(input logic [7:0] d, input logic s, input logic i);
    int src = s ? mq : int'(d);
    return (src + (i ? 1 : 0)) % 256;
  endfunction

  // drive at negedge, check output mid-period, then apply model at posedge
  task automatic cycle(input logic [7:0] d, input logic s, input logic i,
                       input logic c, input logic l, input string tag);
    int e;
    @(negedge clk);
    in_data = d; sel = s; inc = i; clr = c; ld = l;
    #2;
    e = expect_z(d, s, i);
    if (!s || mknown) check(tag, int'(z_out), e);
    @(posedge clk);
    if (l) begin
      mq = e; mknown = (!s || mknown);
    end else if (c) begin
      mq = 0; mknown = 1'b1;
    end
  endtask

  // show stored value on z_out (sel=1, inc=0), no register update
  task automatic view(input string tag, input int exp);
    @(negedge clk);
    sel = 1'b1; inc = 1'b0; clr = 1'b0; ld = 1'b0;
    #2;
    check(tag, int'(z_out), exp);
    check({tag, "_model"}, mq, exp);
  endtask

  initial begin
    logic [7:0] lfsr = 8'hA5;
    cycle(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    view("R1", 0);
    cycle(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    view("R2", 8'h5A);
    cycle(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    cycle(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    view("R4", 8'h5A);
    cycle(8'h33, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    view("R3", 8'h33);
    cycle(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    view("R3", 8'h33);
    cycle(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    for (int k = 0; k < 5; k++) cycle(8'h77, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    view("R8", 5);
    cycle(8'hFE, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    cycle(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    view("R8", 8'hFF);
    cycle(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    view("R6", 8'h00);
    cycle(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    cycle(8'h80, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    cycle(8'h80, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    // R9: output follows inputs between edges
    @(negedge clk);
    in_data = 8'h10; sel = 1'b0; inc = 1'b0; clr = 1'b0; ld = 1'b0;
    #2 check("R9", int'(z_out), 8'h10);
    in_data = 8'h2F; #2 check("R9", int'(z_out), 8'h2F);
    inc = 1'b1; #2 check("R9", int'(z_out), 8'h30);
    sel = 1'b1; #2 check("R9", int'(z_out), (mq + 1) % 256);
    // mixed patterns
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(lfsr, lfsr[0] ^ lfsr[6], lfsr[2], lfsr[3] & lfsr[1], lfsr[4] & lfsr[7],
            lfsr[2] ? "R6" : "R7");
    end
    view("R4", mq);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule